// File: doc/BRIEF.md
# Serial NOR Sector Erase Sequencer

This block runs one complete sector erase on a serial NOR flash device. It sits above a byte-level SPI engine and drives it one byte at a time. A single start pulse latches a sector address and an addressing-mode code. The sequencer first reads the device status until the write-in-progress flag clears. It then sends write enable, the erase command with its address, and write disable. Each command is a separate chip-select frame, and every frame is followed by a programmable idle gap.

Devices with more than 16 MiB can be used in three ways: always 3 address bytes, always 4 address bytes, or a mixed mode. In the mixed mode the sequencer wraps the erase in enter- and leave-4-byte-addressing commands only when the address lies at or above 16 MiB. An error flagged by the engine during the erase frame is reported with completion, and the leave command is still sent. Polling is bounded: if the device stays busy for too many reads, the run ends with a timeout pulse instead of a done pulse.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `txValid` are all low.
- R2: Each status read is a two-byte frame, 0x05 followed by 0x00. Only bit 0 of the byte received for the second position is taken as the busy flag. Status reads repeat until that bit is 0.
- R3: If `MAX_POLLS` status reads all return bit 0 set, the sequencer pulses `timeout` and sends no further frames. No `done` pulse is given.
- R4: Once the device is idle, the sequencer sends a one-byte frame 0x06, then the erase frame, then a one-byte frame 0x04, in that order.
- R5: The erase frame is 0xD8 followed by the address, most significant byte first. Mode code 0 and mode code 3 send the low 3 bytes. Mode code 1 sends 4 bytes. Mode code 2 sends 4 bytes when the address is at least 0x1000000, and 3 bytes otherwise.
- R6: In mode code 2 with an address at least 0x1000000, a one-byte frame 0xB7 comes between the last status read and 0x06, and a one-byte frame 0xE9 comes after 0x04. In no other case are these frames sent.
- R7: If `rxErr` is high with any byte of the erase frame, `eraseErr` is high alongside `done`. The 0x04 frame and any required 0xE9 frame are still sent. Otherwise `eraseErr` is low at `done`.
- R8: `txFirst` marks the first byte of each frame and `txLast` its last. `txData` stays stable while `txValid` waits for `txReady`. No byte is offered before `rxValid` has returned for the previous byte.
- R9: Between the `rxValid` of a frame's last byte and the first byte of the next frame, `txValid` stays low for at least `GAP_CYCLES` cycles.
- R10: `busy` is high from the cycle after an accepted start until the single-cycle `done` or `timeout` pulse. `busy` is low in that pulse cycle.
- R11: A start pulse received while `busy` is high is ignored. The running erase keeps its address and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins one erase when idle |
| sectorAddr | input | ADDR_W | Sector byte address, latched on start |
| addrMode | input | 2 | 0: 3-byte, 1: 4-byte, 2: mixed, 3: as 0 |
| busy | output | 1 | Erase run in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| timeout | output | 1 | One-cycle pulse when polling gave up |
| eraseErr | output | 1 | Engine error during erase frame, valid with done |
| txValid | output | 1 | Byte offered to the engine |
| txReady | input | 1 | Engine accepts the offered byte |
| txData | output | 8 | Byte to shift out |
| txFirst | output | 1 | Offered byte opens a chip-select frame |
| txLast | output | 1 | Offered byte closes the chip-select frame |
| rxValid | input | 1 | Engine finished the last accepted byte |
| rxData | input | 8 | Byte received during that transfer |
| rxErr | input | 1 | Engine reports an error for that byte |

## Verification
The bench builds the block with `MAX_POLLS` set to 5 and `GAP_CYCLES` set to 3. The small poll limit puts the timeout boundary within reach: four busy reads followed by an idle one must succeed, while five busy reads must time out. The three-cycle gap lets the bench count the idle cycles between frames exactly. Addresses on both sides of 16 MiB are used in every mode code, and the engine model returns a byte with bit 0 set in the first position of every status frame, to catch a design that samples the wrong byte.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_WRDI    = 8'h04;
  localparam logic [7:0] OP_ERASE   = 8'hD8;
  localparam logic [7:0] OP_ENTER4  = 8'hB7;
  localparam logic [7:0] OP_LEAVE4  = 8'hE9;

  localparam logic [1:0] AM_THREE = 2'd0;
  localparam logic [1:0] AM_FOUR  = 2'd1;
  localparam logic [1:0] AM_MIXED = 2'd2;

  typedef enum logic [2:0] {
    FR_STAT, FR_ENTER, FR_WREN, FR_ERASE, FR_WRDI, FR_LEAVE
  } frame_e;

  typedef struct packed {
    logic load;
    logic clrIdx;
    logic incIdx;
    logic capStat;
    logic incPoll;
    logic clrGap;
    logic incGap;
    logic setErr;
  } dp_ctl_t;

endpackage

// File: rtl/nor_erase_dp.sv
module nor_erase_dp
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_POLLS  = 4000000,
  parameter int GAP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  frame_e            frame,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        startMode,
  input  logic [7:0]        rxData,
  output logic [7:0]        curByte,
  output logic              firstByte,
  output logic              lastByte,
  output logic              wip,
  output logic              pollExpired,
  output logic              gapDone,
  output logic              wrap4,
  output logic              errFlag
);

  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int GAP_W  = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(32'h0100_0000);

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        modeQ;
  logic [2:0]        idx;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [7:0]        statQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      modeQ   <= AM_THREE;
      idx     <= '0;
      pollCnt <= '0;
      gapCnt  <= '0;
      statQ   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ   <= startAddr;
        modeQ   <= startMode;
        pollCnt <= '0;
        errFlag <= 1'b0;
      end
      if (ctl.clrIdx)       idx <= '0;
      else if (ctl.incIdx)  idx <= idx + 3'd1;
      if (ctl.incPoll)      pollCnt <= pollCnt + POLL_W'(1);
      if (ctl.capStat)      statQ <= rxData;
      if (ctl.clrGap)       gapCnt <= '0;
      else if (ctl.incGap)  gapCnt <= gapCnt + GAP_W'(1);
      if (ctl.setErr)       errFlag <= 1'b1;
    end
  end

  logic       highAddr, use4;
  logic [2:0] nAddr, frameLen;
  logic [5:0] shamt;
  logic [7:0] addrByte;

  always_comb begin
    highAddr = addrQ >= HIGH_BASE;
    wrap4    = (modeQ == AM_MIXED) && highAddr;
    use4     = (modeQ == AM_FOUR) || wrap4;
    nAddr    = use4 ? 3'd4 : 3'd3;
    shamt    = {nAddr - idx, 3'b000};
    addrByte = 8'(addrQ >> shamt);
    case (frame)
      FR_STAT:  frameLen = 3'd2;
      FR_ERASE: frameLen = nAddr + 3'd1;
      default:  frameLen = 3'd1;
    endcase
    case (frame)
      FR_STAT:  curByte = (idx == 3'd0) ? OP_STATUS : 8'h00;
      FR_ENTER: curByte = OP_ENTER4;
      FR_WREN:  curByte = OP_WREN;
      FR_ERASE: curByte = (idx == 3'd0) ? OP_ERASE : addrByte;
      FR_WRDI:  curByte = OP_WRDI;
      FR_LEAVE: curByte = OP_LEAVE4;
      default:  curByte = 8'h00;
    endcase
    firstByte   = idx == 3'd0;
    lastByte    = idx == frameLen - 3'd1;
    wip         = statQ[0];
    pollExpired = pollCnt >= POLL_W'(MAX_POLLS);
    gapDone     = gapCnt == GAP_W'(GAP_CYCLES - 1);
  end

endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
  import nor_erase_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    txReady,
  input  logic    rxValid,
  input  logic    rxErr,
  input  logic    lastByte,
  input  logic    wip,
  input  logic    pollExpired,
  input  logic    gapDone,
  input  logic    wrap4,
  output dp_ctl_t ctl,
  output frame_e  frame,
  output logic    txValid,
  output logic    busy,
  output logic    done,
  output logic    timeout
);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_GAP, S_DONE, S_TOUT} state_e;

  state_e state, stateNxt;
  frame_e frameNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      frame <= FR_STAT;
    end else begin
      state <= stateNxt;
      frame <= frameNxt;
    end
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    frameNxt = frame;
    case (state)
      S_IDLE: if (start) begin
        ctl.load   = 1'b1;
        ctl.clrIdx = 1'b1;
        frameNxt   = FR_STAT;
        stateNxt   = S_SEND;
      end
      S_SEND: if (txReady) stateNxt = S_WAIT;
      S_WAIT: if (rxValid) begin
        ctl.setErr = (frame == FR_ERASE) && rxErr;
        if (lastByte) begin
          ctl.capStat = frame == FR_STAT;
          ctl.incPoll = frame == FR_STAT;
          ctl.clrGap  = 1'b1;
          stateNxt    = S_GAP;
        end else begin
          ctl.incIdx = 1'b1;
          stateNxt   = S_SEND;
        end
      end
      S_GAP: begin
        if (!gapDone) begin
          ctl.incGap = 1'b1;
        end else begin
          ctl.clrIdx = 1'b1;
          stateNxt   = S_SEND;
          case (frame)
            FR_STAT: begin
              if (wip && pollExpired) stateNxt = S_TOUT;
              else if (!wip)          frameNxt = wrap4 ? FR_ENTER : FR_WREN;
            end
            FR_ENTER: frameNxt = FR_WREN;
            FR_WREN:  frameNxt = FR_ERASE;
            FR_ERASE: frameNxt = FR_WRDI;
            FR_WRDI:  if (wrap4) frameNxt = FR_LEAVE;
                      else       stateNxt = S_DONE;
            default:  stateNxt = S_DONE;
          endcase
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign txValid = state == S_SEND;
  assign busy    = (state == S_SEND) || (state == S_WAIT) || (state == S_GAP);
  assign done    = state == S_DONE;
  assign timeout = state == S_TOUT;

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_erase_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_POLLS  = 4000000,
  parameter int GAP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] sectorAddr,
  input  logic [1:0]        addrMode,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              eraseErr,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txFirst,
  output logic              txLast,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxErr
);

  dp_ctl_t ctl;
  frame_e  frame;
  logic    firstByte, lastByte, wip, pollExpired, gapDone, wrap4;

  nor_erase_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .txReady(txReady),
    .rxValid(rxValid), .rxErr(rxErr), .lastByte(lastByte), .wip(wip),
    .pollExpired(pollExpired), .gapDone(gapDone), .wrap4(wrap4),
    .ctl(ctl), .frame(frame), .txValid(txValid), .busy(busy),
    .done(done), .timeout(timeout)
  );

  nor_erase_dp #(
    .ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS), .GAP_CYCLES(GAP_CYCLES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .frame(frame),
    .startAddr(sectorAddr), .startMode(addrMode), .rxData(rxData),
    .curByte(txData), .firstByte(firstByte), .lastByte(lastByte),
    .wip(wip), .pollExpired(pollExpired), .gapDone(gapDone),
    .wrap4(wrap4), .errFlag(eraseErr)
  );

  assign txFirst = txValid && firstByte;
  assign txLast  = txValid && lastByte;

endmodule

// File: rtl/nor_erase_chk.sv
module nor_erase_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txData,
  input logic       txFirst,
  input logic       txLast
);

  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

  a_r8_marks_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    (txFirst || txLast) |-> txValid);

  a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, timeout}));

  a_r10_idle_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |-> !busy);

  a_r10_offer_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy);

  a_r10_pulse_short: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |=> !(done || timeout));

endmodule

bind nor_erase_seq nor_erase_chk i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .timeout(timeout),
  .txValid(txValid), .txReady(txReady), .txData(txData),
  .txFirst(txFirst), .txLast(txLast)
);

// File: tb/test_nor_erase_seq.sv
module test_nor_erase_seq;

  localparam int MAXP = 5;
  localparam int GAP  = 3;
  localparam int LAT  = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [31:0] sectorAddr = '0;
  logic [1:0] addrMode = '0;
  logic       busy, done, timeout, eraseErr, txValid, txFirst, txLast;
  logic [7:0] txData;
  logic       txReady = 1'b1;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxErr = 1'b0;

  always #4 clk = ~clk;

  nor_erase_seq #(.ADDR_W(32), .MAX_POLLS(MAXP), .GAP_CYCLES(GAP)) i_nor_erase_seq (
    .clk(clk), .rstN(rstN), .start(start), .sectorAddr(sectorAddr),
    .addrMode(addrMode), .busy(busy), .done(done), .timeout(timeout),
    .eraseErr(eraseErr), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txFirst(txFirst), .txLast(txLast),
    .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // engine model: records {first,last,byte}
  logic [9:0] recQ[$];
  logic [9:0] expQ[$];
  int  busyCount = 0;
  int  statReads = 0;
  bit  injErr = 0;
  int  phase = 0;
  int  latCnt = 0;
  logic [7:0] curOp = '0;
  int  pos = 0;
  bit  pendLast = 0;
  bit  gapArmed = 0;
  int  gapCnt = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      phase = 0; txReady = 1'b1; rxValid = 1'b0; rxErr = 1'b0; gapArmed = 0;
    end else begin
      if (gapArmed) begin
        if (txValid) begin
          check(gapCnt >= GAP, "R9", "idle gap cycles", gapCnt, GAP);
          gapArmed = 0;
        end else gapCnt++;
      end
      case (phase)
        1: begin
          txReady = 1'b0;
          latCnt--;
          if (latCnt == 0) begin
            rxValid = 1'b1;
            rxErr = 1'b0;
            if (curOp == 8'h05 && pos == 1) begin
              rxData = (statReads < busyCount) ? 8'h03 : 8'h02;
              statReads++;
            end else begin
              rxData = 8'hFF;
              rxErr = injErr && (curOp == 8'hD8) && pendLast;
            end
            if (pendLast) begin gapArmed = 1; gapCnt = 0; end
            phase = 2;
          end
        end
        2: begin
          rxValid = 1'b0; rxErr = 1'b0; txReady = 1'b1; phase = 0;
        end
        default: rxValid = 1'b0;
      endcase
      if (phase == 0 && txValid && txReady) begin
        recQ.push_back({txFirst, txLast, txData});
        if (txFirst) begin curOp = txData; pos = 0; end else pos++;
        pendLast = txLast;
        latCnt = LAT;
        phase = 1;
      end
    end
  end

  task automatic expOne(input logic [7:0] b);
    expQ.push_back({1'b1, 1'b1, b});
  endtask

  task automatic expStat(input int n);
    for (int i = 0; i < n; i++) begin
      expQ.push_back({1'b1, 1'b0, 8'h05});
      expQ.push_back({1'b0, 1'b1, 8'h00});
    end
  endtask

  task automatic expErase(input logic [31:0] a, input bit four);
    expQ.push_back({1'b1, 1'b0, 8'hD8});
    if (four) expQ.push_back({2'b00, a[31:24]});
    expQ.push_back({2'b00, a[23:16]});
    expQ.push_back({2'b00, a[15:8]});
    expQ.push_back({2'b01, a[7:0]});
  endtask

  task automatic compareFrames(input string req);
    bit ok = (recQ.size() == expQ.size());
    int at = -1;
    if (ok) begin
      for (int i = 0; i < expQ.size(); i++)
        if (at < 0 && recQ[i] !== expQ[i]) at = i;
      ok = (at < 0);
    end
    if (recQ.size() != expQ.size())
      check(0, req, "frame byte count", recQ.size(), expQ.size());
    else if (!ok)
      check(0, req, $sformatf("frame byte %0d {first,last,data}", at), recQ[at], expQ[at]);
    else
      check(1, req, "frames", 0, 0);
  endtask

  bit gotDone, gotTout, gotErr, busyOk;

  task automatic runOp(input logic [31:0] a, input logic [1:0] m, input int nBusy,
                       input bit inj, input bit extraStart);
    recQ.delete(); expQ.delete();
    busyCount = nBusy; statReads = 0; injErr = inj;
    gotDone = 0; gotTout = 0; gotErr = 0; busyOk = 1;
    @(negedge clk);
    sectorAddr = a; addrMode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!busy) busyOk = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done || timeout) begin
        gotDone = done; gotTout = timeout; gotErr = eraseErr;
        if (busy) busyOk = 0;
        break;
      end
      if (!busy) busyOk = 0;
      if (extraStart && c == 7) begin
        start = 1'b1; sectorAddr = 32'h0000_0100; addrMode = 2'd1;
      end else start = 1'b0;
    end
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(!busy, "R10", "busy after end", busy, 0);
  endtask

  task automatic testReset();
    check(!busy && !done && !timeout && !txValid, "R1", "reset outputs",
          {busy, done, timeout, txValid}, 0);
  endtask

  task automatic testThreeByte();
    runOp(32'h00AB_CDEF, 2'd0, 0, 0, 0);
    expStat(1); expOne(8'h06); expErase(32'h00AB_CDEF, 0); expOne(8'h04);
    compareFrames("R4 R5 R8");
    check(gotDone && !gotTout, "R4", "done pulse", gotDone, 1);
    check(!gotErr, "R7", "no error", gotErr, 0);
    check(busyOk, "R10", "busy window", busyOk, 1);
  endtask

  task automatic testFourByte();
    runOp(32'h0123_4567, 2'd1, 2, 0, 0);
    expStat(3); expOne(8'h06); expErase(32'h0123_4567, 1); expOne(8'h04);
    compareFrames("R2 R5 R6");
    check(gotDone, "R2", "done after polling", gotDone, 1);
  endtask

  task automatic testMixedLow();
    runOp(32'h00FF_FFFF, 2'd2, 0, 0, 0);
    expStat(1); expOne(8'h06); expErase(32'h00FF_FFFF, 0); expOne(8'h04);
    compareFrames("R5 R6 mixed below 16MiB");
    check(gotDone, "R5", "done", gotDone, 1);
  endtask

  task automatic testMixedHigh();
    runOp(32'h0100_0000, 2'd2, 1, 0, 0);
    expStat(2); expOne(8'hB7); expOne(8'h06); expErase(32'h0100_0000, 1);
    expOne(8'h04); expOne(8'hE9);
    compareFrames("R6 mixed at 16MiB");
    check(gotDone && !gotErr, "R6", "done clean", {gotDone, gotErr}, 2);
  endtask

  task automatic testMode3();
    runOp(32'h01AB_CDEF, 2'd3, 0, 0, 0);
    expStat(1); expOne(8'h06); expErase(32'h01AB_CDEF, 0); expOne(8'h04);
    compareFrames("R5 mode code 3");
  endtask

  task automatic testErrorHigh();
    runOp(32'h0200_0000, 2'd2, 0, 1, 0);
    expStat(1); expOne(8'hB7); expOne(8'h06); expErase(32'h0200_0000, 1);
    expOne(8'h04); expOne(8'hE9);
    compareFrames("R7 leave still sent");
    check(gotDone && gotErr, "R7", "eraseErr with done", {gotDone, gotErr}, 3);
  endtask

  task automatic testErrorClears();
    runOp(32'h0000_1000, 2'd0, 0, 0, 0);
    check(gotDone && !gotErr, "R7", "error cleared on next run", gotErr, 0);
  endtask

  task automatic testTimeout();
    runOp(32'h0000_2000, 2'd0, MAXP, 0, 0);
    expStat(MAXP);
    compareFrames("R3 only status reads");
    check(gotTout && !gotDone, "R3", "timeout pulse", {gotTout, gotDone}, 2);
    check(busyOk, "R10", "busy window at timeout", busyOk, 1);
  endtask

  task automatic testLastPoll();
    runOp(32'h0000_3000, 2'd0, MAXP - 1, 0, 0);
    expStat(MAXP); expOne(8'h06); expErase(32'h0000_3000, 0); expOne(8'h04);
    compareFrames("R3 idle on final allowed read");
    check(gotDone && !gotTout, "R3", "done at limit", {gotDone, gotTout}, 2);
  endtask

  task automatic testRestartIgnored();
    runOp(32'h0055_6677, 2'd0, 2, 0, 1);
    expStat(3); expOne(8'h06); expErase(32'h0055_6677, 0); expOne(8'h04);
    compareFrames("R11 start while busy");
    check(gotDone, "R11", "single done", gotDone, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testThreeByte();
    testFourByte();
    testMixedLow();
    testMixedHigh();
    testMode3();
    testErrorHigh();
    testErrorClears();
    testTimeout();
    testLastPoll();
    testRestartIgnored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule